// File: doc/BRIEF.md
# Cascadable Priority Encoder

This block turns a set of active-low request lines into the index of the most urgent one. The line with the highest number wins. The block is built from identical 8-lane stages, and each stage follows an enable-in / enable-out / group-select handshake.

A stage only looks at its own requests when its enable-in is low. It passes enable further down only when it is enabled and none of its own lines is requesting. It drives group-select low when it has produced a code. A parameter sets how many stages are chained: one, two or four, giving 8, 16 or 32 lanes.

The top level forms one active-low index from the stages. The low index bits are the bitwise AND of the stage codes. The high index bits come from the group-select lines of the stages. The block is purely combinational and has no clock.

Top module: `pe_cascade`

## Requirements
- R1: Every input and output is active-low. `code_n` is the bitwise inverse of the winning lane index. In an 8-lane stage, lane 7 gives 3'b000 and lane 0 gives 3'b111.
- R2: While `en_n` is high, `code_n`, `gs_n` and `eo_n` are all high, whatever `req_n` holds.
- R3: While `en_n` is low and every `req_n` bit is high, `code_n` and `gs_n` are all ones and `eo_n` is low.
- R4: While `en_n` is low and at least one `req_n` bit is low, `code_n` reports the highest-numbered low lane, `gs_n` is low and `eo_n` is high.
- R5: Once a lane is requesting, the state of every lower-numbered lane has no effect on any output.
- R6: Each stage's enable-out feeds the enable-in of the stage just below it. At most one stage drives its group-select low at any time.
- R7: For `STAGES` of 2 or 4, `code_n` is 4 or 5 bits wide. The bits above bit 2 carry the inverted number of the stage that is active. These upper bits are all ones when no stage is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_n | input | 1 | Active-low enable for the whole chain |
| req_n | input | 8*STAGES | Active-low request lines; the highest index has top priority |
| code_n | output | log2(8*STAGES) | Inverted index of the winning lane |
| gs_n | output | 1 | Low when enabled and any lane is requesting |
| eo_n | output | 1 | Low when enabled and no lane is requesting; used to cascade further |

## Verification
The immediate assertions check on every input change, inside each stage, that a disabled stage is silent and that group-select and enable-out are never low together. They also check that an idle enabled stage passes enable on. At the top level they check that only one stage claims the request. The bench alone can show that the right lane wins and that lower lanes really are ignored. It does this by comparing every output against a top-down reference scan: it sweeps all 8-bit patterns over each stage position with enable both high and low, then adds random wide patterns on both the 16-lane and 32-lane builds.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int unsigned MAX_LANES = 32;

  // Index of the highest set bit of an active-high vector (0 when empty).
  function automatic int unsigned hi_index(input logic [MAX_LANES-1:0] act);
    int unsigned idx;
    idx = 0;
    for (int unsigned i = 0; i < MAX_LANES; i++) begin
      if (act[i]) idx = i;
    end
    return idx;
  endfunction

  // Active-low upper index bit b: low when any active stage number has bit b set.
  function automatic logic upper_bit_n(input logic [MAX_LANES-1:0] grp_n,
                                       input int unsigned stages,
                                       input int unsigned b);
    logic acc;
    acc = 1'b1;
    for (int unsigned s = 0; s < MAX_LANES; s++) begin
      if (s < stages && ((s >> b) & 1) == 1) acc = acc & grp_n[s];
    end
    return acc;
  endfunction
endpackage

// File: rtl/pe_stage.sv
module pe_stage #(
  parameter int unsigned LANES = 8,
  localparam int unsigned IW = $clog2(LANES)
) (
  input  logic             en_n,
  input  logic [LANES-1:0] req_n,
  output logic [IW-1:0]    code_n,
  output logic             gs_n,
  output logic             eo_n
);
  import pe_pkg::*;

  logic          any_req;
  logic          granted;
  logic [IW-1:0] win_idx;

  assign any_req = ~&req_n;
  assign granted = ~en_n & any_req;

  always_comb begin
    logic [MAX_LANES-1:0] act;
    act = '0;
    act[LANES-1:0] = ~req_n;
    win_idx = IW'(hi_index(act));
  end

  assign code_n = granted ? ~win_idx : '1;
  assign gs_n   = ~granted;
  assign eo_n   = en_n | any_req;

  // Assertions guarding the stage handshake
  always_comb begin
    if (en_n) begin
      p_disabled_quiet_r2: assert (gs_n && eo_n && (&code_n))
        else $error("disabled stage drives an output low");
    end
    p_gs_eo_exclusive_r4: assert (gs_n || eo_n)
      else $error("group-select and enable-out both low");
    if (!en_n && (&req_n)) begin
      p_idle_passes_enable_r3: assert (!eo_n && gs_n && (&code_n))
        else $error("idle enabled stage did not pass enable");
    end
    if (gs_n) begin
      p_code_idle_r1: assert (&code_n)
        else $error("code driven without group-select");
    end
  end
endmodule

// File: rtl/pe_merge.sv
module pe_merge #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LANES  = 8,
  localparam int unsigned IW = $clog2(LANES),
  localparam int unsigned SW = (STAGES > 1) ? $clog2(STAGES) : 0,
  localparam int unsigned OW = IW + SW
) (
  input  logic [STAGES-1:0][IW-1:0] stage_code_n,
  input  logic [STAGES-1:0]         stage_gs_n,
  output logic [OW-1:0]             code_n,
  output logic                      gs_n
);
  import pe_pkg::*;

  logic [IW-1:0] low_and;

  always_comb begin
    low_and = '1;
    for (int unsigned s = 0; s < STAGES; s++) low_and = low_and & stage_code_n[s];
  end

  assign code_n[IW-1:0] = low_and;
  assign gs_n = &stage_gs_n;

  generate
    if (SW > 0) begin : g_upper
      for (genvar b = 0; b < SW; b++) begin : g_bit
        always_comb begin
          logic [MAX_LANES-1:0] grp;
          grp = '1;
          grp[STAGES-1:0] = stage_gs_n;
          code_n[IW+b] = upper_bit_n(grp, STAGES, b);
        end
      end
    end
  endgenerate

  // Only one stage may claim the request at a time
  always_comb begin
    p_single_group_r6: assert ($countones(~stage_gs_n) <= 1)
      else $error("more than one stage claims group-select");
  end
endmodule

// File: rtl/pe_cascade.sv
module pe_cascade #(
  parameter int unsigned STAGES = 2,
  localparam int unsigned LANES = 8,
  localparam int unsigned TOTAL = LANES * STAGES,
  localparam int unsigned IW = $clog2(LANES),
  localparam int unsigned OW = $clog2(TOTAL)
) (
  input  logic             en_n,
  input  logic [TOTAL-1:0] req_n,
  output logic [OW-1:0]    code_n,
  output logic             gs_n,
  output logic             eo_n
);
  logic [STAGES-1:0][IW-1:0] st_code_n;
  logic [STAGES-1:0]         st_gs_n;
  logic [STAGES-1:0]         st_eo_n;
  logic [STAGES-1:0]         st_en_n;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == STAGES - 1) begin : g_head
        assign st_en_n[s] = en_n;
      end else begin : g_link
        assign st_en_n[s] = st_eo_n[s+1];
      end
      pe_stage #(.LANES(LANES)) stage_i (
        .en_n  (st_en_n[s]),
        .req_n (req_n[s*LANES +: LANES]),
        .code_n(st_code_n[s]),
        .gs_n  (st_gs_n[s]),
        .eo_n  (st_eo_n[s])
      );
    end
  endgenerate

  pe_merge #(.STAGES(STAGES), .LANES(LANES)) merge_i (
    .stage_code_n(st_code_n),
    .stage_gs_n  (st_gs_n),
    .code_n      (code_n),
    .gs_n        (gs_n)
  );

  assign eo_n = st_eo_n[0];

  // Chain-level checks
  always_comb begin
    p_gs_eo_top_r4: assert (gs_n || eo_n)
      else $error("chain reports both request and idle");
    if (!en_n && !(&req_n)) begin
      p_request_seen_r4: assert (!gs_n && eo_n)
        else $error("request present but chain reports idle");
    end
    if (en_n) begin
      p_chain_quiet_r2: assert (gs_n && eo_n && (&code_n))
        else $error("disabled chain drives an output low");
    end
  end
endmodule

// File: tb/pe_cascade_tb_top.sv
module pe_cascade_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;

  logic        en2_n, en4_n;
  logic [15:0] req2_n;
  logic [31:0] req4_n;
  logic [3:0]  code2_n;
  logic [4:0]  code4_n;
  logic        gs2_n, eo2_n, gs4_n, eo4_n;

  pe_cascade #(.STAGES(2)) dut_i (
    .en_n(en2_n), .req_n(req2_n), .code_n(code2_n), .gs_n(gs2_n), .eo_n(eo2_n));
  pe_cascade #(.STAGES(4)) dut4_i (
    .en_n(en4_n), .req_n(req4_n), .code_n(code4_n), .gs_n(gs4_n), .eo_n(eo4_n));

  // Reference: scan from the top lane downward; returns {code_n(5), gs_n, eo_n}.
  function automatic logic [6:0] model(input logic en, input logic [31:0] rq, input int width);
    int bits;
    logic [4:0] code;
    bits = (width == 16) ? 4 : 5;
    if (en) return 7'b1111111;
    for (int i = width - 1; i >= 0; i--) begin
      if (!rq[i]) begin
        code = ~5'(i);
        if (bits == 4) code[4] = 1'b1;
        return {code, 1'b0, 1'b1};
      end
    end
    return {5'b11111, 1'b1, 1'b0};
  endfunction

  task automatic check16(input string req, input logic en, input logic [15:0] rq);
    logic [6:0] exp, got;
    en2_n = en; req2_n = rq;
    #(CLK_PERIOD/2);
    exp = model(en, {16'hFFFF, rq}, 16);
    got = {1'b1, code2_n, gs2_n, eo2_n};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s en_n=%b req_n=%h actual=%b expected=%b", req, en, rq, got, exp);
    end
  endtask

  task automatic check32(input string req, input logic en, input logic [31:0] rq);
    logic [6:0] exp, got;
    en4_n = en; req4_n = rq;
    #(CLK_PERIOD/2);
    exp = model(en, rq, 32);
    got = {code4_n, gs4_n, eo4_n};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s en_n=%b req_n=%h actual=%b expected=%b", req, en, rq, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    en2_n = 1'b1; req2_n = '1; en4_n = 1'b1; req4_n = '1;
    // Reset state: disabled, nothing requested (R2)
    check16("R2 reset", 1'b1, 16'hFFFF);
    check32("R2 reset", 1'b1, 32'hFFFF_FFFF);
    // Idle enabled chain passes enable (R3)
    check16("R3 idle", 1'b0, 16'hFFFF);
    check32("R3 idle", 1'b0, 32'hFFFF_FFFF);
    // Single-lane codes, extremes of the field (R1, R7)
    check16("R1 lane0", 1'b0, 16'hFFFE);
    check16("R1 lane7", 1'b0, 16'hFF7F);
    check16("R7 lane8", 1'b0, 16'hFEFF);
    check16("R7 lane15", 1'b0, 16'h7FFF);
    check32("R7 lane31", 1'b0, 32'h7FFF_FFFF);
    check32("R7 lane16", 1'b0, 32'hFFFE_FFFF);
    // Everything asserted: top lane wins (R4, R5)
    check16("R5 all", 1'b0, 16'h0000);
    check32("R5 all", 1'b0, 32'h0000_0000);
    // Exhaustive 8-bit sweep over each stage position, both enable levels (R2, R4, R6)
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 256; p++) begin
        check16("R4 low byte", e[0], {8'hFF, p[7:0]});
        check16("R6 high byte", e[0], {p[7:0], 8'($urandom)});
        for (int s = 0; s < 4; s++) begin
          logic [31:0] v;
          v = 32'hFFFF_FFFF;
          v[s*8 +: 8] = p[7:0];
          check32("R6 stage sweep", e[0], v);
        end
      end
    end
    // Lower lanes don't matter once a higher one requests (R5)
    for (int k = 0; k < 200; k++) begin
      logic [31:0] v;
      v = $urandom;
      v[31:20] = 12'hFFF;
      v[19] = 1'b0;
      check32("R5 lower dontcare", 1'b0, v);
    end
    // Random wide patterns, sparse and dense (R4, R7)
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] v;
      v = $urandom | $urandom | (k[0] ? $urandom : 32'h0);
      check32("R7 random", 1'($urandom % 5 == 0), v);
      check16("R4 random", 1'($urandom % 5 == 0), v[15:0]);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule